// File: doc/BRIEF.md
# Instruction Decode and Operand Fetch Stage

This block sits between instruction fetch and the ALU in a 32-bit pipeline whose instructions all have one fixed width. Each cycle it takes a 32-bit instruction word and reads its fixed bit slices. The top six bits are the operation code and the bottom six bits are the function code. Two 5-bit source fields address a 32-entry register file. One 5-bit field is a possible destination, and the low 16 bits are an immediate. The register file is held inside the block and has two read ports and one write-back port.

Two external select inputs steer the stage. The destination select picks which instruction field names the register to be written later. The operand select picks whether the second ALU operand comes from the register file or from the sign-extended immediate. Because of these two selects, the same datapath serves both register-register and register-immediate instructions. The control decoder that drives the selects is outside the block.

All outputs are registered and appear one clock edge after the instruction is presented. The register file storage has no reset and is read synchronously, so it can map onto block RAM. A vector of per-register valid flags gives reset-to-zero behaviour. A parameter chooses whether a read of a register being written at the same edge returns the old contents or the new write data.

Top module: `mdec_stage`

## Requirements
- R1: After each rising edge with reset low, `opcode_o` equals bits 31:26 and `funct_o` equals bits 5:0 of the instruction present before that edge.
- R2: After each edge, `opa_o` holds the register addressed by instruction bits 25:21. When the operand select was 0, `opb_o` holds the register addressed by bits 20:16.
- R3: A register takes `wb_data_i` at a rising edge only when `wb_en_i` is 1. When `wb_en_i` is 0 the register keeps its contents.
- R4: Register 0 always reads as zero, and writes addressed to it have no effect.
- R5: `dst_o` is instruction bits 20:16 when the destination select was 0, and bits 15:11 when it was 1.
- R6: `opb_o` is the sign-extended immediate when the operand select was 1.
- R7: `imm_o` carries instruction bits 15:0 in its low half, and bit 15 copied into every bit above it.
- R8: A synchronous active-high reset makes every register read as zero. On the edge after reset, `opa_o`, `opb_o` and `dst_o` are zero.
- R9: A read of the register being written at the same edge returns the old contents when `BYPASS` is 0, and the new write data when `BYPASS` is 1. From the next edge on, both settings return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word from fetch |
| dst_sel_i | input | 1 | Destination select: 0 = bits 20:16, 1 = bits 15:11 |
| opb_sel_i | input | 1 | Second operand select: 0 = register, 1 = immediate |
| wb_en_i | input | 1 | Write-back enable |
| wb_addr_i | input | 5 | Write-back register number |
| wb_data_i | input | DW | Write-back data |
| opa_o | output | DW | First ALU operand |
| opb_o | output | DW | Second ALU operand |
| imm_o | output | DW | Sign-extended immediate |
| dst_o | output | 5 | Chosen destination register number |
| opcode_o | output | 6 | Operation code field |
| funct_o | output | 6 | Function code field |

## Verification
The hardest case to reach is a read and a write of the same register at one edge. The bench gets there by presenting an instruction whose source field names register 5 while the write-back port writes a new value to register 5 in that same cycle. Two copies of the stage, one built with and one built without the bypass, receive identical stimulus so that their results can be compared. The clearing effect of reset is shown by filling registers with non-zero data and then pulsing reset, which proves the flags hide stored data that the storage itself never clears.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  localparam int INSN_W = 32;
  localparam int RA_W   = 5;
  localparam int IMM_W  = 16;

  typedef struct packed {
    logic [5:0]      opc;
    logic [RA_W-1:0] rs;
    logic [RA_W-1:0] rt;
    logic [RA_W-1:0] rd;
    logic [4:0]      sh;
    logic [5:0]      fn;
  } insn_t;
endpackage

// File: rtl/mdec_regfile.sv
module mdec_regfile #(
  parameter int DW     = 32,
  parameter int NREG   = 32,
  parameter int NRD    = 2,
  parameter bit BYPASS = 1'b0,
  localparam int AW    = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NRD-1:0][AW-1:0]  ra_i,
  output logic [NRD-1:0][DW-1:0]  rd_o,
  input  logic                    we_i,
  input  logic [AW-1:0]           wa_i,
  input  logic [DW-1:0]           wd_i
);
  logic [DW-1:0]   mem [NREG];
  logic [NREG-1:0] vld;
  logic            wr_ok;

  assign wr_ok = we_i && (wa_i != '0);

  // storage without reset so it can map to block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wa_i] <= wd_i;
  end

  // per-entry valid flags give reset-to-zero behaviour
  always_ff @(posedge clk) begin
    if (rst)        vld <= '0;
    else if (wr_ok) vld[wa_i] <= 1'b1;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [DW-1:0] raw_q;
    logic          live_q;

    always_ff @(posedge clk) begin
      raw_q <= mem[ra_i[p]];
    end

    always_ff @(posedge clk) begin
      if (rst) live_q <= 1'b0;
      else     live_q <= vld[ra_i[p]] && (ra_i[p] != '0);
    end

    if (BYPASS) begin : g_byp
      logic          hit_q;
      logic [DW-1:0] fwd_q;
      always_ff @(posedge clk) begin
        if (rst) hit_q <= 1'b0;
        else     hit_q <= wr_ok && (wa_i == ra_i[p]);
        fwd_q <= wd_i;
      end
      assign rd_o[p] = hit_q ? fwd_q : (live_q ? raw_q : '0);
    end else begin : g_nobyp
      assign rd_o[p] = live_q ? raw_q : '0;
    end

    // R4: register 0 always reads zero
    a_r4_zero_read: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ra_i[p]) == '0) |-> rd_o[p] == '0);
  end
endmodule

// File: rtl/mdec_opsel.sv
module mdec_opsel #(
  parameter int DW    = 32,
  parameter int IMM_W = 16
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic             sel_i,
  input  logic [DW-1:0]    reg_i,
  output logic [DW-1:0]    imm_o,
  output logic [DW-1:0]    opb_o
);
  localparam int EXT_W = DW - IMM_W;

  assign imm_o = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign opb_o = sel_i ? imm_o : reg_i;
endmodule

// File: rtl/mdec_stage.sv
module mdec_stage
  import mdec_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NREG   = 32,
  parameter bit BYPASS = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INSN_W-1:0] instr_i,
  input  logic              dst_sel_i,
  input  logic              opb_sel_i,
  input  logic              wb_en_i,
  input  logic [RA_W-1:0]   wb_addr_i,
  input  logic [DW-1:0]     wb_data_i,
  output logic [DW-1:0]     opa_o,
  output logic [DW-1:0]     opb_o,
  output logic [DW-1:0]     imm_o,
  output logic [RA_W-1:0]   dst_o,
  output logic [5:0]        opcode_o,
  output logic [5:0]        funct_o
);
  insn_t                      f;
  logic [IMM_W-1:0]           imm16_q;
  logic                       osel_q;
  logic [1:0][RA_W-1:0]       ra;
  logic [1:0][DW-1:0]         rd;

  assign f  = insn_t'(instr_i);
  assign ra = {f.rt, f.rs};

  mdec_regfile #(.DW(DW), .NREG(NREG), .NRD(2), .BYPASS(BYPASS)) u_rf (
    .clk(clk), .rst(rst), .ra_i(ra), .rd_o(rd),
    .we_i(wb_en_i), .wa_i(wb_addr_i), .wd_i(wb_data_i)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_o    <= '0;
      opcode_o <= '0;
      funct_o  <= '0;
      imm16_q  <= '0;
      osel_q   <= 1'b0;
    end else begin
      dst_o    <= dst_sel_i ? f.rd : f.rt;
      opcode_o <= f.opc;
      funct_o  <= f.fn;
      imm16_q  <= {f.rd, f.sh, f.fn};
      osel_q   <= opb_sel_i;
    end
  end

  assign opa_o = rd[0];

  mdec_opsel #(.DW(DW), .IMM_W(IMM_W)) u_ops (
    .imm_i(imm16_q), .sel_i(osel_q), .reg_i(rd[1]),
    .imm_o(imm_o), .opb_o(opb_o)
  );

  // R1: fields appear one edge later
  a_r1_fields: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (opcode_o == $past(instr_i[31:26]) && funct_o == $past(instr_i[5:0])));
  // R5: destination select
  a_r5_dst: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> dst_o == ($past(dst_sel_i) ? $past(instr_i[15:11]) : $past(instr_i[20:16])));
  // R6: immediate routed to second operand
  a_r6_opb_imm: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opb_sel_i)) |-> opb_o == imm_o);
  // R7: sign extension of the previous immediate
  a_r7_sext: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> imm_o == {{(DW-IMM_W){$past(instr_i[15])}}, $past(instr_i[15:0])});
  // R8: outputs cleared by reset
  a_r8_reset_out: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (opa_o == '0 && opb_o == '0 && dst_o == '0));
endmodule

// File: tb/mdec_stage_bench.sv
module mdec_stage_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic        dsel = 1'b0, osel = 1'b0, we = 1'b0;
  logic [4:0]  wa = '0;
  logic [31:0] wd = '0;
  logic [31:0] opa, opb, imm, opa_b, opb_b, imm_b;
  logic [4:0]  dst, dst_b;
  logic [5:0]  opc, fn, opc_b, fn_b;
  logic [31:0] model [32];
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  mdec_stage u_mdec_stage (
    .clk(clk), .rst(rst), .instr_i(instr), .dst_sel_i(dsel), .opb_sel_i(osel),
    .wb_en_i(we), .wb_addr_i(wa), .wb_data_i(wd),
    .opa_o(opa), .opb_o(opb), .imm_o(imm), .dst_o(dst), .opcode_o(opc), .funct_o(fn));

  mdec_stage #(.BYPASS(1'b1)) u_mdec_stage_byp (
    .clk(clk), .rst(rst), .instr_i(instr), .dst_sel_i(dsel), .opb_sel_i(osel),
    .wb_en_i(we), .wb_addr_i(wa), .wb_data_i(wd),
    .opa_o(opa_b), .opb_o(opb_b), .imm_o(imm_b), .dst_o(dst_b), .opcode_o(opc_b), .funct_o(fn_b));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] lo);
    return {op, rs, rt, lo};
  endfunction

  task automatic step(input logic [31:0] i, input logic ds, input logic os,
                      input logic e, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    instr = i; dsel = ds; osel = os; we = e; wa = a; wd = d;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    step(32'h0, 1'b0, 1'b0, 1'b1, a, d);
    if (a != 0) model[a] = d;
  endtask

  task automatic t_reset_state;
    chk(opa == 0 && opb == 0 && dst == 0, "R8 outputs in reset", opa | opb, 32'h0);
    @(negedge clk); rst = 1'b0;
    step(mk(6'd0, 5'd9, 5'd9, 16'h0), 1'b0, 1'b0, 1'b0, 5'd0, 32'h0);
    chk(opa == 0 && opb == 0, "R8 register reads zero", opa, 32'h0);
  endtask

  task automatic t_rformat;
    wr(5'd9, 32'h1111_1111);
    wr(5'd10, 32'h2222_2222);
    step(32'h012A4020, 1'b1, 1'b0, 1'b0, 5'd0, 32'h0);
    chk(opa == model[9], "R2 rs read", opa, model[9]);
    chk(opb == model[10], "R2 rt read", opb, model[10]);
    chk(dst == 5'd8, "R5 dst sel=1", {27'd0, dst}, 32'd8);
    chk(opc == 6'd0 && fn == 6'h20, "R1 opcode/funct", {20'd0, opc, fn}, {26'd0, 6'h20});
  endtask

  task automatic t_iformat;
    wr(5'd22, 32'h0000_0100);
    step(32'h22D5FFCE, 1'b0, 1'b1, 1'b0, 5'd0, 32'h0);
    chk(opa == model[22], "R2 rs read I", opa, model[22]);
    chk(dst == 5'd21, "R5 dst sel=0", {27'd0, dst}, 32'd21);
    chk(imm == 32'hFFFF_FFCE, "R7 negative imm", imm, 32'hFFFF_FFCE);
    chk(opb == 32'hFFFF_FFCE, "R6 opb imm", opb, 32'hFFFF_FFCE);
    chk(opc == 6'h08, "R1 opcode I", {26'd0, opc}, 32'h8);
    step(mk(6'h0D, 5'd22, 5'd9, 16'h7FFF), 1'b0, 1'b0, 1'b0, 5'd0, 32'h0);
    chk(imm == 32'h0000_7FFF, "R7 positive imm", imm, 32'h0000_7FFF);
    chk(opb == model[9], "R6 opb reg", opb, model[9]);
  endtask

  task automatic t_wen;
    step(32'h0, 1'b0, 1'b0, 1'b0, 5'd9, 32'hDEAD_BEEF);
    step(mk(6'd0, 5'd9, 5'd0, 16'h0), 1'b0, 1'b0, 1'b0, 5'd0, 32'h0);
    chk(opa == model[9], "R3 no write when disabled", opa, model[9]);
    wr(5'd9, 32'h3333_4444);
    step(mk(6'd0, 5'd9, 5'd0, 16'h0), 1'b0, 1'b0, 1'b0, 5'd0, 32'h0);
    chk(opa == 32'h3333_4444, "R3 write when enabled", opa, 32'h3333_4444);
  endtask

  task automatic t_zero;
    wr(5'd0, 32'hFFFF_FFFF);
    step(mk(6'd0, 5'd0, 5'd0, 16'h0), 1'b0, 1'b0, 1'b0, 5'd0, 32'h0);
    chk(opa == 0 && opb == 0, "R4 reg0 zero", opa | opb, 32'h0);
    chk(opa_b == 0, "R4 reg0 zero bypass", opa_b, 32'h0);
  endtask

  task automatic t_same_cycle;
    wr(5'd5, 32'hAAAA_0005);
    step(mk(6'd0, 5'd5, 5'd5, 16'h0), 1'b0, 1'b0, 1'b1, 5'd5, 32'h5555_0005);
    chk(opa == 32'hAAAA_0005, "R9 old value no bypass", opa, 32'hAAAA_0005);
    chk(opa_b == 32'h5555_0005, "R9 new value bypass", opa_b, 32'h5555_0005);
    model[5] = 32'h5555_0005;
    step(mk(6'd0, 5'd5, 5'd5, 16'h0), 1'b0, 1'b0, 1'b0, 5'd0, 32'h0);
    chk(opa == model[5] && opa_b == model[5], "R9 next read new", opa, model[5]);
  endtask

  task automatic t_reset_clear;
    @(negedge clk); rst = 1'b1; we = 1'b0;
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 32; k++) model[k] = '0;
    step(mk(6'd0, 5'd9, 5'd22, 16'h0), 1'b0, 1'b0, 1'b0, 5'd0, 32'h0);
    chk(opa == 0 && opb == 0, "R8 reset clears regs", opa | opb, 32'h0);
    chk(opa_b == 0 && opb_b == 0, "R8 reset clears regs bypass", opa_b | opb_b, 32'h0);
  endtask

  initial begin
    for (int k = 0; k < 32; k++) model[k] = '0;
    @(posedge clk); @(posedge clk); #1;
    t_reset_state();
    t_rformat();
    t_iformat();
    t_wen();
    t_zero();
    t_same_cycle();
    t_reset_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule